// File: doc/BRIEF.md
# Stepper Micro-Step Phase Sequencer

This block drives the electrical position of a group of four motor-drive channels around an eight-phase cycle. A shared position is kept as a phase index (0 to 7) and a step index inside that phase. Each channel reports the shared phase offset by its own start phase. A step tick moves the position by one or two steps, upward or downward. The number of steps in one phase is selectable among 8, 16, 32 and 64. A square-wave mode moves a whole phase per tick and gives a two-level output per channel instead of micro-step positions.

A run begins on the rising edge of the enable input. At that edge the block captures its configuration and the four start phases. It stops by itself once a programmed number of phase changes has been made and flags this with a one-clock done pulse. Dropping enable halts the run at once, and the position is kept. All pins are plain control and status signals. The tick is a single-cycle strobe with no handshake and cannot be held off, so there is no back-pressure. The outputs are levels that may be sampled in any cycle.

Top module: `stepseq_top`

## Requirements
- R1: After reset, busy and done are 0, step index is 0, every channel phase is 0 and every square level is 0.
- R2: On the clock edge where enable is first seen high, the configuration and start phases are captured, the step index becomes 0, each channel phase equals its own start phase, and busy becomes 1.
- R3: The steps-per-phase select encodes 0=8, 1=16, 2=32, 3=64 steps; the step index stays below the selected length and wraps into the next phase when it reaches it.
- R4: With the two-unit select at 0 each tick moves one step; with it at 1 each tick moves two steps.
- R5: Direction 0 raises step and phase; direction 1 lowers them, and a downward move from below one unit borrows: the step becomes length minus unit and the phase drops by one.
- R6: Channel phase is (start phase + shared phase) modulo 8 and wraps in both directions; a single tick changes it by at most one.
- R7: With a non-zero phase count, the tick that makes that many phase changes ends the run: done is 1 for exactly one clock, busy drops, and later ticks leave the position unchanged. A count of 0 means no automatic stop.
- R8: In square mode each tick moves exactly one phase, the step index stays 0, and a channel's square level (bit c of the level output is channel c) is 1 while its phase is 0 to 3 and 0 while it is 4 to 7; outside square mode all levels are 0.
- R9: Enable low stops motion from the next edge and the position holds under ticks; raising enable again restarts from the start phases.
- R10: Configuration inputs changed during a run have no effect until the next enable rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run enable; a rise starts a run |
| step_tick_i | input | 1 | One-cycle strobe, one move per high cycle |
| dir_i | input | 1 | 0 upward (counterclockwise), 1 downward (clockwise) |
| spp_sel_i | input | 2 | Steps per phase: 0=8, 1=16, 2=32, 3=64 |
| two_unit_i | input | 1 | 0 one step per tick, 1 two steps per tick |
| square_i | input | 1 | 1 selects square-wave mode |
| phase_count_i | input | CNT_W | Phase changes before automatic stop, 0 for none |
| start_phase_i | input | NUM_CH*3 | Start phase per channel, channel c in bits [3c+2:3c] |
| ch_phase_o | output | NUM_CH*3 | Current phase per channel, same packing |
| step_o | output | 6 | Step index inside the phase |
| sq_level_o | output | NUM_CH | Square-wave level per channel |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-clock pulse when the phase count is reached |

## Verification
The main function is driven through a vector table that crosses all four step lengths with both step units and both directions. Tick counts are chosen to land just short of a phase boundary, exactly on one, and several phases beyond it. Landing short of the boundary tells the carry point apart from an off-by-one. Downward runs from step 0 separate a correct borrow from a plain wrap. Starts at phases 0, 5 and 7 expose missing modulo-8 wrap, and the per-channel start offsets show that each channel adds its own offset. Directed runs then separate the auto-stop boundary (one tick before versus at the count), square-mode levels at a load and after several ticks, enable loss against auto-stop, and configuration changes during a run against captured settings.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  localparam int PH_W   = 3;
  localparam int STEP_W = 6;
  localparam int LEN_W  = STEP_W + 1;

  typedef enum logic [1:0] {SPP_8 = 2'd0, SPP_16 = 2'd1, SPP_32 = 2'd2, SPP_64 = 2'd3} spp_e;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

  typedef struct packed {
    dir_e dir;
    spp_e spp;
    logic two_unit;
    logic square;
  } run_cfg_t;

  function automatic logic [LEN_W-1:0] spp_len(spp_e sel);
    logic [LEN_W-1:0] base;
    base = LEN_W'(8);
    return base << sel;
  endfunction
endpackage

// File: rtl/stepseq_step_ctr.sv
module stepseq_step_ctr
  import stepseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  input  dir_e              dir_i,
  input  spp_e              spp_i,
  input  logic              two_unit_i,
  input  logic              square_i,
  output logic [STEP_W-1:0] step_o,
  output logic              wrap_o
);
  logic [LEN_W-1:0] len, unit, cur, sum, nxt;
  logic             wrap;

  always_comb begin
    len  = spp_len(spp_i);
    unit = two_unit_i ? LEN_W'(2) : LEN_W'(1);
    cur  = {1'b0, step_o};
    sum  = cur + unit;
    nxt  = cur;
    wrap = 1'b0;
    if (square_i) begin
      nxt  = '0;
      wrap = 1'b1;
    end else if (dir_i == DIR_UP) begin
      if (sum >= len) begin
        nxt  = sum - len;
        wrap = 1'b1;
      end else begin
        nxt = sum;
      end
    end else begin
      if (cur < unit) begin
        nxt  = cur + len - unit;
        wrap = 1'b1;
      end else begin
        nxt = cur - unit;
      end
    end
  end

  assign wrap_o = adv_i & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_o <= '0;
    else if (clr_i)  step_o <= '0;
    else if (adv_i)  step_o <= nxt[STEP_W-1:0];
  end
endmodule

// File: rtl/stepseq_phase_acc.sv
module stepseq_phase_acc
  import stepseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wrap_i,
  input  dir_e             dir_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [PH_W-1:0]  base_o,
  output logic             finish_o
);
  logic [CNT_W-1:0] moved;

  assign finish_o = wrap_i && (limit_i != '0) && ((moved + CNT_W'(1)) == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_o <= '0;
      moved  <= '0;
    end else if (clr_i) begin
      base_o <= '0;
      moved  <= '0;
    end else if (wrap_i) begin
      base_o <= (dir_i == DIR_UP) ? base_o + PH_W'(1) : base_o - PH_W'(1);
      moved  <= moved + CNT_W'(1);
    end
  end
endmodule

// File: rtl/stepseq_chan_map.sv
module stepseq_chan_map
  import stepseq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH*PH_W-1:0] starts_i,
  input  logic [PH_W-1:0]        base_i,
  input  logic                   square_i,
  output logic [NUM_CH*PH_W-1:0] phase_o,
  output logic [NUM_CH-1:0]      level_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PH_W-1:0] ph;
    assign ph = starts_i[c*PH_W +: PH_W] + base_i;
    assign phase_o[c*PH_W +: PH_W] = ph;
    assign level_o[c] = square_i & ~ph[PH_W-1];
  end
endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
  import stepseq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable_i,
  input  logic                   step_tick_i,
  input  logic                   dir_i,
  input  logic [1:0]             spp_sel_i,
  input  logic                   two_unit_i,
  input  logic                   square_i,
  input  logic [CNT_W-1:0]       phase_count_i,
  input  logic [NUM_CH*3-1:0]    start_phase_i,
  output logic [NUM_CH*3-1:0]    ch_phase_o,
  output logic [5:0]             step_o,
  output logic [NUM_CH-1:0]      sq_level_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int ST_W = NUM_CH * PH_W;

  run_cfg_t         cfg_q;
  logic [CNT_W-1:0] limit_q;
  logic [ST_W-1:0]  starts_q;
  logic             en_q, running, finish, wrap, advance, launch;
  logic [PH_W-1:0]  base;

  assign launch  = enable_i & ~en_q;
  assign advance = running & enable_i & step_tick_i & ~launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      running  <= 1'b0;
      done_o   <= 1'b0;
      cfg_q    <= '{dir: DIR_UP, spp: SPP_8, two_unit: 1'b0, square: 1'b0};
      limit_q  <= '0;
      starts_q <= '0;
    end else begin
      en_q   <= enable_i;
      done_o <= finish;
      if (launch) begin
        running  <= 1'b1;
        cfg_q    <= '{dir: dir_e'(dir_i), spp: spp_e'(spp_sel_i),
                      two_unit: two_unit_i, square: square_i};
        limit_q  <= phase_count_i;
        starts_q <= start_phase_i;
      end else if (!enable_i || finish) begin
        running <= 1'b0;
      end
    end
  end

  stepseq_step_ctr u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (launch),
    .adv_i      (advance),
    .dir_i      (cfg_q.dir),
    .spp_i      (cfg_q.spp),
    .two_unit_i (cfg_q.two_unit),
    .square_i   (cfg_q.square),
    .step_o     (step_o),
    .wrap_o     (wrap)
  );

  stepseq_phase_acc #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (launch),
    .wrap_i   (wrap),
    .dir_i    (cfg_q.dir),
    .limit_i  (limit_q),
    .base_o   (base),
    .finish_o (finish)
  );

  stepseq_chan_map #(.NUM_CH(NUM_CH)) u_map (
    .starts_i (starts_q),
    .base_i   (base),
    .square_i (cfg_q.square),
    .phase_o  (ch_phase_o),
    .level_o  (sq_level_o)
  );

  assign busy_o = running;
endmodule

// File: rtl/stepseq_chk.sv
module stepseq_chk
  import stepseq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enable_i,
  input logic                   step_tick_i,
  input logic [NUM_CH*3-1:0]    ch_phase_o,
  input logic [5:0]             step_o,
  input logic                   busy_o,
  input logic                   done_o,
  input spp_e                   spp_q,
  input logic                   square_q
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !enable_i) |=> ($stable(ch_phase_o) && $stable(step_o)));

  p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, step_o} < spp_len(spp_q));

  p_square_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    square_q |-> (step_o == 6'd0));

  p_one_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && enable_i && step_tick_i) |=>
      ((ch_phase_o[2:0] == $past(ch_phase_o[2:0])) ||
       (ch_phase_o[2:0] == $past(ch_phase_o[2:0]) + 3'd1) ||
       (ch_phase_o[2:0] == $past(ch_phase_o[2:0]) - 3'd1)));
endmodule

bind stepseq_top stepseq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .step_tick_i (step_tick_i),
  .ch_phase_o  (ch_phase_o),
  .step_o      (step_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .spp_q       (cfg_q.spp),
  .square_q    (cfg_q.square)
);

// File: tb/test_stepseq_top.sv
module test_stepseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 16;

  typedef struct packed {
    logic [1:0] spp;
    logic       two;
    logic       dir;
    logic [2:0] s;
    logic [7:0] ticks;
    logic [2:0] ph;
    logic [5:0] st;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{spp: 2'd0, two: 1'b0, dir: 1'b0, s: 3'd0, ticks: 8'd8,  ph: 3'd1, st: 6'd0},
    '{spp: 2'd0, two: 1'b0, dir: 1'b0, s: 3'd0, ticks: 8'd5,  ph: 3'd0, st: 6'd5},
    '{spp: 2'd1, two: 1'b1, dir: 1'b0, s: 3'd2, ticks: 8'd9,  ph: 3'd3, st: 6'd2},
    '{spp: 2'd2, two: 1'b0, dir: 1'b1, s: 3'd0, ticks: 8'd1,  ph: 3'd7, st: 6'd31},
    '{spp: 2'd3, two: 1'b1, dir: 1'b1, s: 3'd5, ticks: 8'd33, ph: 3'd3, st: 6'd62},
    '{spp: 2'd0, two: 1'b0, dir: 1'b0, s: 3'd7, ticks: 8'd17, ph: 3'd1, st: 6'd1},
    '{spp: 2'd1, two: 1'b0, dir: 1'b1, s: 3'd3, ticks: 8'd16, ph: 3'd2, st: 6'd0},
    '{spp: 2'd2, two: 1'b1, dir: 1'b0, s: 3'd6, ticks: 8'd48, ph: 3'd1, st: 6'd0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            enable_i = 1'b0;
  logic            step_tick_i = 1'b0;
  logic            dir_i = 1'b0;
  logic [1:0]      spp_sel_i = 2'd0;
  logic            two_unit_i = 1'b0;
  logic            square_i = 1'b0;
  logic [CW-1:0]   phase_count_i = '0;
  logic [NCH*3-1:0] start_phase_i = '0;
  logic [NCH*3-1:0] ch_phase_o;
  logic [5:0]      step_o;
  logic [NCH-1:0]  sq_level_o;
  logic            busy_o, done_o;

  int tests = 0;
  int fails = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepseq_top #(.NUM_CH(NCH), .CNT_W(CW)) i_stepseq_top (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .step_tick_i(step_tick_i),
    .dir_i(dir_i), .spp_sel_i(spp_sel_i), .two_unit_i(two_unit_i),
    .square_i(square_i), .phase_count_i(phase_count_i),
    .start_phase_i(start_phase_i), .ch_phase_o(ch_phase_o), .step_o(step_o),
    .sq_level_o(sq_level_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      step_tick_i = 1'b1;
      repeat (n) @(negedge clk);
      step_tick_i = 1'b0;
    end
  endtask

  task automatic start_run();
    enable_i = 1'b0;
    @(negedge clk);
    enable_i = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [2:0] chp(input int c);
    return ch_phase_o[c*3 +: 3];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 step", step_o, 0);
    check("R1 phases", ch_phase_o, 0);
    check("R1 levels", sq_level_o, 0);

    // R3 R4 R5 R6 vector table, free-running count
    for (int v = 0; v < 8; v++) begin
      logic [2:0] d;
      spp_sel_i = VECS[v].spp;
      two_unit_i = VECS[v].two;
      dir_i = VECS[v].dir;
      square_i = 1'b0;
      phase_count_i = '0;
      start_phase_i = {3'd7, 3'd4, 3'd1, VECS[v].s};
      start_run();
      ticks(VECS[v].ticks);
      d = VECS[v].ph - VECS[v].s;
      check($sformatf("R3_R4_R5 vec%0d step", v), step_o, VECS[v].st);
      check($sformatf("R6 vec%0d ch0", v), chp(0), VECS[v].ph);
      check($sformatf("R6 vec%0d ch1", v), chp(1), 3'(3'd1 + d));
      check($sformatf("R6 vec%0d ch3", v), chp(3), 3'(3'd7 + d));
      check($sformatf("R8 vec%0d micro levels", v), sq_level_o, 0);
    end

    // R2 load of start phases
    spp_sel_i = 2'd0; two_unit_i = 1'b1; dir_i = 1'b0; square_i = 1'b0;
    phase_count_i = 16'd2;
    start_phase_i = {3'd6, 3'd3, 3'd5, 3'd0};
    start_run();
    check("R2 busy", busy_o, 1);
    check("R2 step", step_o, 0);
    check("R2 phases", ch_phase_o, {3'd6, 3'd3, 3'd5, 3'd0});

    // R7 auto-stop after two phase changes (4 ticks per phase)
    ticks(7);
    check("R7 no done early", done_o, 0);
    check("R7 busy early", busy_o, 1);
    check("R7 step early", step_o, 6);
    ticks(1);
    check("R7 done", done_o, 1);
    check("R7 busy low", busy_o, 0);
    check("R7 ch0 final", chp(0), 2);
    check("R7 step final", step_o, 0);
    @(negedge clk);
    check("R7 done one clock", done_o, 0);
    ticks(3);
    check("R7 hold ch0", chp(0), 2);
    check("R7 hold step", step_o, 0);

    // R8 square mode
    square_i = 1'b1; phase_count_i = '0;
    start_phase_i = {3'd6, 3'd4, 3'd2, 3'd0};
    start_run();
    check("R8 levels at load", sq_level_o, 4'b0011);
    ticks(3);
    check("R8 ch0 after 3", chp(0), 3);
    check("R8 step zero", step_o, 0);
    check("R8 levels after 3", sq_level_o, 4'b1001);

    // R9 enable drop holds, rise restarts
    square_i = 1'b0; two_unit_i = 1'b0; spp_sel_i = 2'd0;
    start_phase_i = {3'd1, 3'd2, 3'd3, 3'd4};
    start_run();
    ticks(3);
    enable_i = 1'b0;
    @(negedge clk);
    ticks(2);
    check("R9 busy off", busy_o, 0);
    check("R9 step held", step_o, 3);
    check("R9 ch0 held", chp(0), 4);
    enable_i = 1'b1;
    @(negedge clk);
    check("R9 restart step", step_o, 0);
    check("R9 restart ch0", chp(0), 4);
    check("R9 restart busy", busy_o, 1);

    // R10 config changes during a run are ignored
    dir_i = 1'b1; spp_sel_i = 2'd3; two_unit_i = 1'b1; square_i = 1'b1;
    phase_count_i = 16'd1;
    ticks(8);
    check("R10 ch0 uses captured cfg", chp(0), 5);
    check("R10 step uses captured cfg", step_o, 0);
    check("R10 still busy", busy_o, 1);
    check("R10 levels unchanged", sq_level_o, 0);

    report();
  end
endmodule